// File: doc/BRIEF.md
# Masked Control and Interrupt Register Block

This block holds the control and interrupt state of an audio DMA front end. A 32-bit control word is written through a masked scheme. The upper half of each written word says which bits of the lower half may change. Software can therefore turn a single control bit on or off without first reading the register. The stored bits drive a self-clearing reset request, a port enable and three per-channel transfer enables.

Five event pulses feed a status register. The events are two playback channels, one capture channel, and a start and an error event from a serial controller. Status bits stay set until software writes ones to them. An enable register picks which status bits reach the single level-sensitive interrupt line. Access uses a plain word-addressed bus with write enable, read enable, address, write data and read data. Writes take effect at the clock edge. Reads are combinational.

The block has no state machine: its behaviour is fully described by its three registers, with no sequencing beyond the one-cycle reset request.

Top module: `mcr_regblock`

## Requirements
- R1: After synchronous reset (`rst`), every register reads zero, all control outputs are low and `irq_o` is low.
- R2: A write to the control word (address 0) changes control bit n (0..15) only when bit n+16 of the written word is 1. Bits whose enable is 0 keep their value.
- R3: In a control write, an enabled bit n becomes 1 when written bit n is 1, and becomes 0 when written bit n is 0.
- R4: Reading address 0 returns the 16 stored control bits in bits 15:0, with zeros in bits 31:16.
- R5: Event input bit k (0 = playback A, 1 = playback B, 2 = capture, 3 = serial start, 4 = serial error) sets status bit k one cycle later, whatever the enable register holds. Status is read at address 2 in bits 4:0.
- R6: A write to address 2 clears exactly the status bits written as 1 and leaves the rest unchanged.
- R7: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_o` is high exactly when some status bit and the same enable bit (address 1, bits 4:0) are both 1. Writing zero to the enable register masks every source.
- R9: Control bit 0 is the reset request. Setting it drives `rst_req_o` high for exactly one cycle. In the next cycle the control, enable and status registers all read zero, apart from status bits set by events arriving in that cycle.
- R10: Writes to address 3 change nothing, and reads of address 3 return zero.
- R11: `port_en_o` follows control bit 1, and `xfer_en_o[i]` follows control bit 2+i (i = 0 playback A, 1 playback B, 2 capture).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when `rd_en` is low |
| evt_i | input | 5 | Event pulses, one bit per source |
| rst_req_o | output | 1 | Reset request (control bit 0) |
| port_en_o | output | 1 | Audio port enable (control bit 1) |
| xfer_en_o | output | 3 | Per-channel transfer enables (control bits 4:2) |
| irq_o | output | 1 | Level interrupt |

## Verification
A write or an event presented before a clock edge shows up in the registers, the control outputs and `irq_o` right after that edge. A read shows the stored value in the same cycle, because `rdata` is combinational. The reset request is high for the single cycle after the write that sets it, and the cleared state appears one edge later. The bench drives inputs on falling edges and samples outputs at the next falling edge, so every result is read one full edge after its cause. Reads are sampled 1 ns after the address is applied.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int DATA_W   = 32;
    localparam int CTL_W    = DATA_W / 2;
    localparam int EVT_W    = 5;
    localparam int ADDR_W   = 2;
    localparam int XFER_W   = 3;

    localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENA = 2'd1;
    localparam logic [ADDR_W-1:0] A_STS = 2'd2;

    localparam int B_RST  = 0;
    localparam int B_PORT = 1;
    localparam int B_XFER = 2;
endpackage

// File: rtl/mcr_ctl_mask.sv
module mcr_ctl_mask #(
    parameter int CTL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               we,
    input  logic [2*CTL_W-1:0] wdata,
    output logic [CTL_W-1:0]   ctl_q
);
    logic [CTL_W-1:0] mask;
    logic [CTL_W-1:0] nxt;

    always_comb begin
        mask = wdata[2*CTL_W-1:CTL_W];
        nxt  = (ctl_q & ~mask) | (wdata[CTL_W-1:0] & mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            ctl_q <= '0;
        else if (we)
            ctl_q <= nxt;
    end
endmodule

// File: rtl/mcr_irq.sv
module mcr_irq #(
    parameter int EVT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we_ena,
    input  logic             we_sts,
    input  logic [EVT_W-1:0] wbits,
    input  logic [EVT_W-1:0] evt,
    output logic [EVT_W-1:0] ena_q,
    output logic [EVT_W-1:0] sts_q,
    output logic             irq
);
    logic [EVT_W-1:0] w1c;

    always_comb w1c = we_sts ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= '0;
            sts_q <= '0;
        end else if (clr) begin
            ena_q <= '0;
            sts_q <= evt;
        end else begin
            if (we_ena)
                ena_q <= wbits;
            sts_q <= (sts_q & ~w1c) | evt;
        end
    end

    always_comb irq = |(sts_q & ena_q);
endmodule

// File: rtl/mcr_regblock.sv
module mcr_regblock
    import mcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              rst_req_o,
    output logic              port_en_o,
    output logic [XFER_W-1:0] xfer_en_o,
    output logic              irq_o
);
    logic [CTL_W-1:0] ctl_q;
    logic [EVT_W-1:0] ena_q;
    logic [EVT_W-1:0] sts_q;
    logic             soft_clr;
    logic             we_ctl, we_ena, we_sts;

    always_comb begin
        soft_clr = ctl_q[B_RST];
        we_ctl   = wr_en && (addr == A_CTL);
        we_ena   = wr_en && (addr == A_ENA);
        we_sts   = wr_en && (addr == A_STS);
    end

    mcr_ctl_mask #(.CTL_W(CTL_W)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .clr   (soft_clr),
        .we    (we_ctl),
        .wdata (wdata),
        .ctl_q (ctl_q)
    );

    mcr_irq #(.EVT_W(EVT_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .clr    (soft_clr),
        .we_ena (we_ena),
        .we_sts (we_sts),
        .wbits  (wdata[EVT_W-1:0]),
        .evt    (evt_i),
        .ena_q  (ena_q),
        .sts_q  (sts_q),
        .irq    (irq_o)
    );

    always_comb begin
        rst_req_o = ctl_q[B_RST];
        port_en_o = ctl_q[B_PORT];
        xfer_en_o = ctl_q[B_XFER +: XFER_W];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_CTL:   rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
                A_ENA:   rdata = {{(DATA_W-EVT_W){1'b0}}, ena_q};
                A_STS:   rdata = {{(DATA_W-EVT_W){1'b0}}, sts_q};
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mcr_regblock_chk.sv
module mcr_regblock_chk
    import mcr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [EVT_W-1:0]  evt_i,
    input logic [EVT_W-1:0]  sts_q,
    input logic              rst_req_o,
    input logic              port_en_o,
    input logic [XFER_W-1:0] xfer_en_o,
    input logic              irq_o
);
    // R9
    rst_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> (!rst_req_o && !port_en_o && xfer_en_o == '0 && !irq_o));

    // R2
    other_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != A_CTL && !rst_req_o) |=> $stable({port_en_o, xfer_en_o}));

    // R3
    masked_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTL && wdata[CTL_W+B_PORT] && wdata[B_PORT] && !rst_req_o)
        |=> port_en_o);

    // R3
    masked_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTL && wdata[CTL_W+B_PORT] && !wdata[B_PORT]) |=> !port_en_o);

    // R5
    evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> (|sts_q));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i[0] && wr_en && addr == A_STS && wdata[0]) |=> sts_q[0]);

    // R8
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ENA && wdata[EVT_W-1:0] == '0) |=> !irq_o);
endmodule

bind mcr_regblock mcr_regblock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .evt_i     (evt_i),
    .sts_q     (sts_q),
    .rst_req_o (rst_req_o),
    .port_en_o (port_en_o),
    .xfer_en_o (xfer_en_o),
    .irq_o     (irq_o)
);

// File: tb/mcr_regblock_test.sv
`timescale 1ns/1ps
module mcr_regblock_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [4:0]  evt_i;
    logic        rst_req_o, port_en_o, irq_o;
    logic [2:0]  xfer_en_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] m_ctl;
    logic [31:0] rv;

    always #5 clk = ~clk;

    mcr_regblock uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_i(evt_i), .rst_req_o(rst_req_o),
        .port_en_o(port_en_o), .xfer_en_o(xfer_en_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic chk_outs(input string req);
        check(req, {27'd0, rst_req_o, port_en_o, xfer_en_o}, {27'd0, m_ctl[0], m_ctl[1], m_ctl[4:2]});
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; evt_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], rv); check("R1", rv, 32'd0);
        end
        check("R1", {31'd0, irq_o}, 32'd0);
        m_ctl = '0;
        chk_outs("R1");

        // R2 R3 R4 R11: sweep bits 1..15, set then clear, with extra noise bits unmasked
        for (int n = 1; n < 16; n++) begin
            logic [31:0] d;
            d = (32'h1 << (n + 16)) | (32'h1 << n) | 32'h0000_FFFE;
            wr(2'd0, d);
            m_ctl = (m_ctl & ~d[31:16]) | (d[15:0] & d[31:16]);
            rd(2'd0, rv); check("R3", rv, {16'd0, m_ctl});
            check("R4", {16'd0, rv[31:16]}, 32'd0);
            chk_outs("R11");
        end
        for (int n = 1; n < 16; n++) begin
            logic [31:0] d;
            d = (32'h1 << (n + 16)) | (n[0] ? 32'h0000_FFFE : 32'h0);
            wr(2'd0, d);
            m_ctl = (m_ctl & ~d[31:16]) | (d[15:0] & d[31:16]);
            rd(2'd0, rv); check("R2", rv, {16'd0, m_ctl});
            chk_outs("R11");
        end
        // R2: mask all zero changes nothing
        wr(2'd0, 32'h0000_FFFE);
        rd(2'd0, rv); check("R2", rv, {16'd0, m_ctl});

        // R10: address 3 ignored
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, rv); check("R10", rv, 32'd0);
        rd(2'd0, rv); check("R10", rv, {16'd0, m_ctl});
        rd(2'd1, rv); check("R10", rv, 32'd0);
        rd(2'd2, rv); check("R10", rv, 32'd0);

        // R5 R6 R8: exhaustive status x enable
        for (int s = 0; s < 32; s++) begin
            for (int e = 0; e < 32; e++) begin
                wr(2'd1, e);
                pulse(s[4:0]);
                rd(2'd2, rv); check("R5", rv, s);
                check("R8", {31'd0, irq_o}, {31'd0, |(s[4:0] & e[4:0])});
                wr(2'd2, 32'h0000_0015);
                rd(2'd2, rv); check("R6", rv, s & 32'h0A);
                wr(2'd2, 32'hFFFF_FFFF);
            end
        end
        // R8: zero enable masks all
        pulse(5'h1F);
        wr(2'd1, 32'h0);
        check("R8", {31'd0, irq_o}, 32'd0);
        wr(2'd2, 32'h1F);

        // R7: set wins over clear on same bit
        pulse(5'h1F);
        @(negedge clk);
        evt_i = 5'b00100; wr_en = 1'b1; addr = 2'd2; wdata = 32'h1F;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0;
        rd(2'd2, rv); check("R7", rv, 32'h04);

        // R9: reset request
        wr(2'd1, 32'h1F);
        m_ctl = m_ctl | 16'h001E;
        wr(2'd0, 32'h001E_001E);
        m_ctl = 16'h001E;
        wr(2'd0, 32'h0001_0001);
        check("R9", {31'd0, rst_req_o}, 32'd1);
        evt_i = 5'b10000;
        @(negedge clk);
        evt_i = '0;
        check("R9", {31'd0, rst_req_o}, 32'd0);
        m_ctl = '0;
        chk_outs("R9");
        rd(2'd0, rv); check("R9", rv, 32'd0);
        rd(2'd1, rv); check("R9", rv, 32'd0);
        rd(2'd2, rv); check("R9", rv, 32'h10);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule